// File: doc/BRIEF.md
# Byte-Lane Store Wrapper for Word-Only Parity Storage

This block puts a byte-addressed request port in front of a storage array that can only be read or written one whole 32-bit word at a time. Every stored word has one extra parity bit. A requester issues loads and stores of 1, 2 or 4 bytes. The wrapper drops the low address bits to form the word index and works out which byte lanes the store touches. It then steers the requester's right-aligned data onto those lanes.

A store that covers all four lanes goes straight into the array in the cycle it is accepted. A narrower store cannot be written on its own, so the wrapper performs a read-merge-write. It reads the word, replaces only the enabled lanes, computes fresh parity and writes the full word back. While this sequence runs, the wrapper refuses new requests. A load always returns the complete word, and the requester picks out the bytes it needs. Every word read from the array has its parity checked. A mismatch sets a sticky error flag, which stays set until the requester clears it.

Top module: `byte_rmw_mem`

## Requirements
- R1: After reset, `req_ready` is 1, `rd_valid` is 0 and `par_err` is 0.
- R2: The word index is `req_addr[ADDR_W-1:2]`. A word access ignores `req_addr[1:0]`, and a halfword access ignores `req_addr[0]`.
- R3: Lanes are little-endian: lane k holds bits 8k+7..8k, and lane k is byte offset k. The size codes are 2'b00 for a byte, 2'b01 for a halfword and 2'b10 (or 2'b11) for a word. A byte store puts `req_wdata[7:0]` on lane `req_addr[1:0]`. A halfword store puts `req_wdata[15:0]` on lanes 0-1 when `req_addr[1]`=0 and on lanes 2-3 when it is 1.
- R4: Lanes that a store does not enable keep their stored contents. Bits of `req_wdata` above the store size never reach the array.
- R5: A word store finishes in the cycle it is accepted, and `req_ready` stays 1 in the next cycle.
- R6: A byte or halfword store takes three cycles: `req_ready` is 0 for exactly the two cycles after acceptance.
- R7: An accepted load gives `rd_valid`=1 with the whole word on `rd_data` in the next cycle. At all other times `rd_valid` is 0.
- R8: A load accepted in the first cycle after a read-merge-write to the same word returns the merged word.
- R9: Each word is written with even parity over all 33 bits. A word that was written correctly never raises `par_err`. A parity mismatch on any array read sets `par_err` one cycle after the read data appears, and `par_err` then stays set.
- R10: A one-cycle pulse on `err_clr` clears `par_err`. If a new mismatch arrives in the same cycle, the flag stays set.
- R11: A request has no effect when `req_valid` is 0, or when it is presented while `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Store data, right-aligned |
| req_ready | output | 1 | Wrapper can accept a request this cycle |
| rd_valid | output | 1 | Load data valid |
| rd_data | output | 32 | Whole word read |
| err_clr | input | 1 | Clears the parity error flag |
| par_err | output | 1 | Sticky parity error flag |

## Verification
If the merge goes wrong, the error stays hidden until a later load of that word. The bench therefore reads back every word it stores a byte or halfword into, and checks all four lanes. A control state stuck in the read-merge-write sequence shows up as `req_ready` held wrong within one to three cycles of the store. Wrong parity generation shows up as a spurious `par_err` on the first load of a word with an odd number of set bits. The mismatch path is exercised by overriding the array's read word for one load.

// File: rtl/byte_rmw_pkg.sv
package byte_rmw_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int DATA_W = LANES * BYTE_W;
    localparam int WORD_W = DATA_W + 1;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_WRITE = 2'b10
    } state_e;

    typedef struct packed {
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] data;
    } lane_req_t;

    function automatic logic even_bit(input logic [DATA_W-1:0] d);
        return ^d;
    endfunction

    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] old_w,
        input logic [DATA_W-1:0] new_w,
        input logic [LANES-1:0]  be
    );
        logic [DATA_W-1:0] r;
        for (int i = 0; i < LANES; i++)
            r[i*BYTE_W +: BYTE_W] = be[i] ? new_w[i*BYTE_W +: BYTE_W]
                                          : old_w[i*BYTE_W +: BYTE_W];
        return r;
    endfunction
endpackage

// File: rtl/rmw_lane_decode.sv
module rmw_lane_decode
    import byte_rmw_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int WADDR_W = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [1:0]         size,
    input  logic [DATA_W-1:0]  wdata,
    output logic [WADDR_W-1:0] word_addr,
    output lane_req_t          lanes
);
    logic [OFF_W-1:0] off;
    size_e            sz;

    assign off       = addr[OFF_W-1:0];
    assign word_addr = addr[ADDR_W-1:OFF_W];
    assign sz        = size_e'(size);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            unique case (sz)
                SZ_BYTE: begin
                    lanes.be[i] = (off == OFF_W'(i));
                    lanes.data[i*BYTE_W +: BYTE_W] = wdata[BYTE_W-1:0];
                end
                SZ_HALF: begin
                    lanes.be[i] = (off[OFF_W-1] == ((i / 2) != 0));
                    lanes.data[i*BYTE_W +: BYTE_W] = wdata[(i % 2)*BYTE_W +: BYTE_W];
                end
                default: begin
                    lanes.be[i] = 1'b1;
                    lanes.data[i*BYTE_W +: BYTE_W] = wdata[i*BYTE_W +: BYTE_W];
                end
            endcase
        end
    end
endmodule

// File: rtl/rmw_word_array.sv
module rmw_word_array
    import byte_rmw_pkg::*;
#(
    parameter int WADDR_W = 6,
    localparam int DEPTH = 1 << WADDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [WADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0]  rd_word,
    input  logic               wr_en,
    input  logic [WADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0]  wr_word
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_word <= '0;
        else if (rd_en)
            rd_word <= mem[rd_addr];
    end

    // R9: every word entering the array carries even parity over 33 bits
    assert_even_store_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((^wr_word) == 1'b0));
endmodule

// File: rtl/rmw_parity_monitor.sv
module rmw_parity_monitor
    import byte_rmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_en,
    input  logic [WORD_W-1:0] word,
    input  logic              clr,
    output logic              err
);
    logic hit;

    assign hit = chk_en && ((^word) != 1'b0);

    always_ff @(posedge clk) begin
        if (rst)
            err <= 1'b0;
        else
            err <= (err && !clr) || hit;
    end

    // R9: once raised, the flag holds until a clear
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (err && !clr) |=> err);
    // R10: clear without a new mismatch drops the flag
    assert_err_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !err);
endmodule

// File: rtl/byte_rmw_mem.sv
module byte_rmw_mem
    import byte_rmw_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int WADDR_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic              err_clr,
    output logic              par_err
);
    state_e             state_q;
    logic [WADDR_W-1:0] dec_addr, st_addr_q;
    lane_req_t          dec_lanes, st_lanes_q;
    logic [WORD_W-1:0]  arr_q;
    logic               accept, is_full;
    logic               arr_rd_en, arr_wr_en, chk_en_q, rd_valid_q;
    logic [WADDR_W-1:0] arr_rd_addr, arr_wr_addr;
    logic [WORD_W-1:0]  arr_wr_word;
    logic [DATA_W-1:0]  merged;

    rmw_lane_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr      (req_addr),
        .size      (req_size),
        .wdata     (req_wdata),
        .word_addr (dec_addr),
        .lanes     (dec_lanes)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign is_full   = &dec_lanes.be;
    assign merged    = lane_merge(arr_q[DATA_W-1:0], st_lanes_q.data, st_lanes_q.be);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            st_addr_q  <= '0;
            st_lanes_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept && req_write && !is_full) begin
                    state_q    <= ST_READ;
                    st_addr_q  <= dec_addr;
                    st_lanes_q <= dec_lanes;
                end
                ST_READ:  state_q <= ST_WRITE;
                ST_WRITE: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        arr_rd_en   = (accept && !req_write) || (state_q == ST_READ);
        arr_rd_addr = (state_q == ST_READ) ? st_addr_q : dec_addr;
        arr_wr_en   = (accept && req_write && is_full) || (state_q == ST_WRITE);
        if (state_q == ST_WRITE) begin
            arr_wr_addr = st_addr_q;
            arr_wr_word = {even_bit(merged), merged};
        end else begin
            arr_wr_addr = dec_addr;
            arr_wr_word = {even_bit(dec_lanes.data), dec_lanes.data};
        end
    end

    rmw_word_array #(.WADDR_W(WADDR_W)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (arr_rd_en),
        .rd_addr (arr_rd_addr),
        .rd_word (arr_q),
        .wr_en   (arr_wr_en),
        .wr_addr (arr_wr_addr),
        .wr_word (arr_wr_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_en_q   <= 1'b0;
            rd_valid_q <= 1'b0;
        end else begin
            chk_en_q   <= arr_rd_en;
            rd_valid_q <= accept && !req_write;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = arr_q[DATA_W-1:0];

    rmw_parity_monitor u_par (
        .clk    (clk),
        .rst    (rst),
        .chk_en (chk_en_q),
        .word   (arr_q),
        .clr    (err_clr),
        .err    (par_err)
    );

    // R6: partial store holds off requests for exactly two cycles
    assert_rmw_window_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && req_write && !is_full) |=> !req_ready ##1 !req_ready ##1 req_ready);
    // R5: full-word store does not stall
    assert_full_nostall_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && req_write && is_full) |=> req_ready);
    // R7: load data appears exactly one cycle after a load is accepted
    assert_load_valid_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_write) |=> rd_valid);
    assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (rst)
        !(accept && !req_write) |=> !rd_valid);
endmodule

// File: tb/tb_byte_rmw_mem.sv
`timescale 1ns/1ps
module tb_byte_rmw_mem;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, err_clr;
    logic [7:0]  req_addr;
    logic [1:0]  req_size;
    logic [31:0] req_wdata;
    logic        req_ready, rd_valid, par_err;
    logic [31:0] rd_data;
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    byte_rmw_mem #(.ADDR_W(8)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .err_clr(err_clr), .par_err(par_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // tasks start and end at a negative clock edge
    task automatic do_store(input logic [7:0] a, input logic [1:0] sz,
                            input logic [31:0] d, input string req);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        if (sz[1]) begin
            chk({req, " R5 ready after word store"}, 32'(req_ready), 32'd1);
        end else begin
            chk({req, " R6 ready low cycle 1"}, 32'(req_ready), 32'd0);
            @(negedge clk);
            chk({req, " R6 ready low cycle 2"}, 32'(req_ready), 32'd0);
            @(negedge clk);
            chk({req, " R6 ready back"}, 32'(req_ready), 32'd1);
        end
    endtask

    task automatic do_load(input logic [7:0] a, input logic [31:0] exp, input string req);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = 2'b10; req_wdata = '0;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk({req, " R7 rd_valid"}, 32'(rd_valid), 32'd1);
        chk({req, " data"}, rd_data, exp);
    endtask

    task automatic t_reset();
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 rd_valid", 32'(rd_valid), 32'd0);
        chk("R1 par_err", 32'(par_err), 32'd0);
    endtask

    task automatic t_word();
        do_store(8'h10, 2'b10, 32'h1122_3344, "word");
        do_store(8'h17, 2'b11, 32'h0000_0001, "word alt code R2");
        @(negedge clk);
        chk("R7 rd_valid idle", 32'(rd_valid), 32'd0);
        do_load(8'h12, 32'h1122_3344, "R2 word ignores low bits");
        do_load(8'h14, 32'h0000_0001, "R9 odd weight word");
        chk("R9 no false error", 32'(par_err), 32'd0);
    endtask

    task automatic t_bytes();
        do_store(8'h20, 2'b10, 32'h0000_0000, "prefill");
        for (int k = 0; k < 4; k++)
            do_store(8'h20 + 8'(k), 2'b00, 32'hFFFF_FF00 | 32'(8'hA0 + k), "R3 byte lane");
        do_load(8'h20, 32'hA3A2_A1A0, "R8 load right after merge R3 R4");
        do_store(8'h24, 2'b10, 32'h5555_5555, "prefill");
        do_store(8'h26, 2'b00, 32'h1234_5677, "R4 one byte");
        do_load(8'h24, 32'h5577_5555, "R4 other lanes kept");
    endtask

    task automatic t_half();
        do_store(8'h30, 2'b10, 32'h5555_5555, "prefill");
        do_store(8'h31, 2'b01, 32'hAAAA_BEEF, "R2 half ignores addr0");
        do_load(8'h30, 32'h5555_BEEF, "R3 low half");
        do_store(8'h33, 2'b01, 32'h7777_CAFE, "R3 high half");
        do_load(8'h30, 32'hCAFE_BEEF, "R3 R8 high half merged");
    endtask

    task automatic t_ignored();
        do_store(8'h40, 2'b10, 32'h0102_0304, "prefill");
        req_write = 1'b1; req_addr = 8'h40; req_size = 2'b10; req_wdata = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        chk("R11 no load valid when idle", 32'(rd_valid), 32'd0);
        // partial store, then a second store held while not ready
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h44; req_size = 2'b00; req_wdata = 32'h0000_0099;
        @(posedge clk); @(negedge clk);
        req_addr = 8'h40; req_size = 2'b10; req_wdata = 32'hDEAD_BEEF;
        chk("R11 R6 ready low", 32'(req_ready), 32'd0);
        @(negedge clk);
        chk("R11 R6 ready low 2", 32'(req_ready), 32'd0);
        req_valid = 1'b0;
        @(negedge clk);
        do_load(8'h40, 32'h0102_0304, "R11 word untouched");
    endtask

    task automatic t_parity();
        chk("R9 clean so far", 32'(par_err), 32'd0);
        force dut.arr_q = 33'h1_0000_0000;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h10; req_size = 2'b10;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        release dut.arr_q;
        chk("R9 mismatch sets flag", 32'(par_err), 32'd1);
        do_load(8'h10, 32'h1122_3344, "R9 clean load");
        @(negedge clk);
        chk("R9 flag sticky", 32'(par_err), 32'd1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk("R10 clear", 32'(par_err), 32'd0);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_size = '0; req_wdata = '0; err_clr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_word();
        t_bytes();
        t_half();
        t_ignored();
        t_parity();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule